// File: doc/BRIEF.md
# State Retention and Isolation Register Bank

This block is a small register bank that lives in a power domain that can be switched off. It also models what happens to that bank across a sleep cycle. Each functional bit may have a shadow copy, chosen by a parameter mask. The shadow copies run on the always-on clock and keep their contents while the domain is unpowered. An active-high save captures the live contents into the shadows. A restore issued once the domain is powered and out of reset copies them back.

While power is absent, the functional contents are replaced by a fixed corrupt pattern. While the isolation enable is high, every output bit that crosses into the always-on logic is clamped to its own configured value. A typical sleep sequence has these steps:

1. Save the state.
2. Raise isolation.
3. Drop power.
4. Restore power with the domain reset held.
5. Release the reset.
6. Restore the state.
7. Lower isolation.

A three-state domain controller tracks power and reset. Its states are:

- `DOM_OFF`: unpowered, or powered but not yet reset.
- `DOM_RESET`: powered, with the domain reset held.
- `DOM_RUN`: powered, with the reset released.

Its transitions are:

- OFF→RESET when power is good and the domain reset is low.
- RESET→RUN when the domain reset is released.
- RUN→RESET when the domain reset is asserted again.
- RESET→OFF and RUN→OFF whenever power-good falls.

The bank is *live* when power is good, the domain reset is high and the controller is not in `DOM_OFF`. Save, restore and write take effect only while the bank is live.

Top module: `pwr_ret_bank`

## Requirements
- R1: After the always-on reset `aon_rst_n`, with isolation low, `q_out` shows the corrupt pattern 8'hA5 and `seq_err` is 0.
- R2: When `pwr_good` is high and `dom_rst_n` is low, the functional bits take the reset default 8'h00 on the next clock. A domain that powers up with its reset already released stays at the corrupt pattern, and ignores writes, until a domain reset is seen.
- R3: When the bank is live, isolation is low and no restore is pending, `wr_en` loads `wr_data` into the functional bits, visible at `q_out` after the next clock.
- R4: Writes issued while isolation is high, or while `pwr_good` is low, are discarded.
- R5: One clock after `pwr_good` is seen low, the functional bits hold the corrupt pattern 8'hA5.
- R6: While `iso_en` is high, `q_out` equals the clamp value 8'h81 (bit 0, the enable bit, is clamped high) and does not follow the functional bits; the clamp acts without a clock.
- R7: A clock on which `save_req` is high and the bank is live copies the retained bits (mask 8'h0F, the low nibble) into the shadows. The falling edge of `save_req` captures nothing.
- R8: A restore on a live bank replaces the retained bits with their shadow values and leaves the non-retained bits (high nibble) unchanged.
- R9: Shadow contents survive power-off and domain reset. After a full sleep cycle, the restored low nibble equals the value last saved, and the high nibble shows the reset default.
- R10: A save requested while the bank is not live (unpowered or in domain reset) leaves the shadows unchanged.
- R11: When save and restore are high in the same live clock, the save takes effect and the restore is dropped. `seq_err` is then high for the one following clock and low otherwise.
- R12: When restore and write fall in the same live clock, the restore wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| aon_rst_n | input | 1 | Always-on reset, active low |
| pwr_good | input | 1 | Domain supply is up |
| dom_rst_n | input | 1 | Domain reset, active low |
| save_req | input | 1 | Save to shadows, active high |
| restore_req | input | 1 | Restore from shadows, active high |
| iso_en | input | 1 | Clamp outputs to configured values |
| wr_en | input | 1 | Functional write enable |
| wr_data | input | WIDTH | Functional write data |
| q_out | output | WIDTH | Isolated register contents |
| seq_err | output | 1 | Save and restore collided on the previous clock |

## Verification
Directed sequences run a complete sleep cycle with a changing data pattern. The saved low nibble differs from both the corrupt pattern and the reset default, so a lost shadow, a missing restore or a save taken while unpowered each produce a distinct value. A save pulse followed at once by a new write separates level capture from capture on the falling edge. Collisions of save with restore, and of restore with write, show which operation has priority. Constrained random cycles then mix power drops, domain resets, isolation, saves, restores and writes, and each cycle is compared against a bench model built from the requirements.

// File: rtl/pwr_ret_pkg.sv
package pwr_ret_pkg;
    typedef enum logic [1:0] {
        DOM_OFF   = 2'd0,
        DOM_RESET = 2'd1,
        DOM_RUN   = 2'd2
    } dom_state_e;
endpackage

// File: rtl/pwr_dom_fsm.sv
module pwr_dom_fsm
    import pwr_ret_pkg::*;
(
    input  logic       clk,
    input  logic       aon_rst_n,
    input  logic       pwr_good,
    input  logic       dom_rst_n,
    output dom_state_e state,
    output logic       live
);
    dom_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!aon_rst_n) state <= DOM_OFF;
        else            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            DOM_OFF:   if (pwr_good && !dom_rst_n) state_nxt = DOM_RESET;
            DOM_RESET: if (!pwr_good)              state_nxt = DOM_OFF;
                       else if (dom_rst_n)         state_nxt = DOM_RUN;
            DOM_RUN:   if (!pwr_good)              state_nxt = DOM_OFF;
                       else if (!dom_rst_n)        state_nxt = DOM_RESET;
            default:                               state_nxt = DOM_OFF;
        endcase
    end

    always_comb begin
        live = pwr_good && dom_rst_n && (state != DOM_OFF);
    end

    // R2: a powered domain that has not seen a reset stays off
    assert_off_until_reset_R2: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (state == DOM_OFF && dom_rst_n) |=> (state == DOM_OFF));
endmodule

// File: rtl/pwr_func_bank.sv
module pwr_func_bank #(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] RET_MASK    = 8'h0F,
    parameter logic [WIDTH-1:0] RST_VAL     = 8'h00,
    parameter logic [WIDTH-1:0] CORRUPT_VAL = 8'hA5
) (
    input  logic             clk,
    input  logic             aon_rst_n,
    input  logic             pwr_good,
    input  logic             dom_rst_n,
    input  logic             live,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             iso_en,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] func_q,
    output logic             seq_err
);
    logic [WIDTH-1:0] shadow;
    logic             do_save;
    logic             do_restore;

    always_comb begin
        do_save    = live && save_req;
        do_restore = live && restore_req && !save_req;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_shadow
        if (RET_MASK[i]) begin : g_ret
            logic sh_q;
            always_ff @(posedge clk) begin
                if (!aon_rst_n)   sh_q <= RST_VAL[i];
                else if (do_save) sh_q <= func_q[i];
            end
            assign shadow[i] = sh_q;
        end else begin : g_noret
            assign shadow[i] = RST_VAL[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!aon_rst_n)               func_q <= CORRUPT_VAL;
        else if (!pwr_good)           func_q <= CORRUPT_VAL;
        else if (!dom_rst_n)          func_q <= RST_VAL;
        else if (!live)               func_q <= func_q;
        else if (do_restore)          func_q <= (shadow & RET_MASK) | (func_q & ~RET_MASK);
        else if (wr_en && !iso_en)    func_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!aon_rst_n) seq_err <= 1'b0;
        else            seq_err <= live && save_req && restore_req;
    end

    assert_corrupt_off_R5: assert property (@(posedge clk) disable iff (!aon_rst_n)
        !pwr_good |=> (func_q == CORRUPT_VAL));
    assert_dom_reset_R2: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (pwr_good && !dom_rst_n) |=> (func_q == RST_VAL));
    assert_save_capture_R7: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (live && save_req) |=> ((shadow & RET_MASK) == ($past(func_q) & RET_MASK)));
    assert_restore_keeps_R8: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (live && restore_req && !save_req) |=> ((func_q & ~RET_MASK) == $past(func_q & ~RET_MASK)));
    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!aon_rst_n)
        !live |=> $stable(shadow));
    assert_seq_err_R11: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (live && save_req && restore_req) |=> seq_err);
endmodule

// File: rtl/pwr_iso_clamp.sv
module pwr_iso_clamp #(
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] CLAMP_VAL = 8'h81
) (
    input  logic             iso_en,
    input  logic [WIDTH-1:0] func_q,
    output logic [WIDTH-1:0] q_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_clamp
        assign q_out[i] = iso_en ? CLAMP_VAL[i] : func_q[i];
    end
endmodule

// File: rtl/pwr_ret_bank.sv
module pwr_ret_bank
    import pwr_ret_pkg::*;
#(
    parameter int               WIDTH       = 8,
    parameter logic [WIDTH-1:0] RET_MASK    = 8'h0F,
    parameter logic [WIDTH-1:0] RST_VAL     = 8'h00,
    parameter logic [WIDTH-1:0] CORRUPT_VAL = 8'hA5,
    parameter logic [WIDTH-1:0] CLAMP_VAL   = 8'h81
) (
    input  logic             clk,
    input  logic             aon_rst_n,
    input  logic             pwr_good,
    input  logic             dom_rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             iso_en,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q_out,
    output logic             seq_err
);
    dom_state_e       dom_state;
    logic             live;
    logic [WIDTH-1:0] func_q;

    pwr_dom_fsm u_fsm (
        .clk       (clk),
        .aon_rst_n (aon_rst_n),
        .pwr_good  (pwr_good),
        .dom_rst_n (dom_rst_n),
        .state     (dom_state),
        .live      (live)
    );

    pwr_func_bank #(
        .WIDTH       (WIDTH),
        .RET_MASK    (RET_MASK),
        .RST_VAL     (RST_VAL),
        .CORRUPT_VAL (CORRUPT_VAL)
    ) u_bank (
        .clk         (clk),
        .aon_rst_n   (aon_rst_n),
        .pwr_good    (pwr_good),
        .dom_rst_n   (dom_rst_n),
        .live        (live),
        .save_req    (save_req),
        .restore_req (restore_req),
        .iso_en      (iso_en),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .func_q      (func_q),
        .seq_err     (seq_err)
    );

    pwr_iso_clamp #(
        .WIDTH     (WIDTH),
        .CLAMP_VAL (CLAMP_VAL)
    ) u_clamp (
        .iso_en (iso_en),
        .func_q (func_q),
        .q_out  (q_out)
    );

    // R6: a held isolation keeps the crossing outputs frozen
    assert_iso_stable_R6: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (iso_en && $past(iso_en)) |-> $stable(q_out));
    // R4: with power gone, the clamp-free output cannot pick up write data
    assert_no_write_off_R4: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (!pwr_good && !iso_en && $past(!pwr_good)) |-> (q_out == CORRUPT_VAL));
endmodule

// File: tb/pwr_ret_bank_bench.sv
module pwr_ret_bank_bench;
    localparam logic [7:0] MASK = 8'h0F;
    localparam logic [7:0] CORR = 8'hA5;
    localparam logic [7:0] CLMP = 8'h81;

    logic       clk = 1'b0;
    logic       aon_rst_n, pwr_good, dom_rst_n, save_req, restore_req, iso_en, wr_en;
    logic [7:0] wr_data;
    logic [7:0] q_out;
    logic       seq_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_func, m_sh;
    logic       m_off, m_err;

    always #5 clk = ~clk;

    pwr_ret_bank u_pwr_ret_bank (
        .clk(clk), .aon_rst_n(aon_rst_n), .pwr_good(pwr_good), .dom_rst_n(dom_rst_n),
        .save_req(save_req), .restore_req(restore_req), .iso_en(iso_en),
        .wr_en(wr_en), .wr_data(wr_data), .q_out(q_out), .seq_err(seq_err)
    );

    function automatic logic [7:0] exp_q();
        return iso_en ? CLMP : m_func;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(logic pg, logic dr, logic iso, logic sv, logic rs, logic we, logic [7:0] wd);
        pwr_good = pg; dom_rst_n = dr; iso_en = iso; save_req = sv;
        restore_req = rs; wr_en = we; wr_data = wd;
    endtask

    task automatic tick();
        logic       lv;
        logic [7:0] nf, ns;
        logic       no, ne;
        lv = pwr_good && dom_rst_n && !m_off;
        if (!pwr_good)                     nf = CORR;
        else if (!dom_rst_n)               nf = 8'h00;
        else if (m_off)                    nf = m_func;
        else if (restore_req && !save_req) nf = (m_sh & MASK) | (m_func & ~MASK);
        else if (wr_en && !iso_en)         nf = wr_data;
        else                               nf = m_func;
        ns = (lv && save_req) ? ((m_func & MASK) | (m_sh & ~MASK)) : m_sh;
        ne = lv && save_req && restore_req;
        no = !pwr_good ? 1'b1 : (!dom_rst_n ? 1'b0 : m_off);
        @(posedge clk);
        #1;
        m_func = nf; m_sh = ns; m_off = no; m_err = ne;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        aon_rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 8'h00);
        repeat (3) @(posedge clk);
        #1;
        aon_rst_n = 1'b1;
        m_func = CORR; m_sh = 8'h00; m_off = 1'b1; m_err = 1'b0;
        #1;
        chk("R1 reset output", q_out, CORR);
        chk("R1 reset err", {7'd0, seq_err}, 8'h00);

        // R2: powered without reset keeps corrupt and drops the write
        drive(1, 1, 0, 0, 0, 1, 8'h11); tick();
        chk("R2 no reset yet", q_out, CORR);
        drive(1, 0, 0, 0, 0, 0, 8'h00); tick();
        chk("R2 domain reset default", q_out, 8'h00);
        drive(1, 1, 0, 0, 0, 0, 8'h00); tick();

        drive(1, 1, 0, 0, 0, 1, 8'hC7); tick();
        chk("R3 write", q_out, 8'hC7);

        drive(1, 1, 1, 0, 0, 0, 8'h00); #1;
        chk("R6 clamp", q_out, CLMP);
        drive(1, 1, 1, 0, 0, 1, 8'h3C); tick();
        chk("R6 clamp held", q_out, CLMP);
        drive(1, 1, 0, 0, 0, 0, 8'h00); #1;
        chk("R4 write under isolation dropped", q_out, 8'hC7);

        // R7: save pulse, then a write right after the fall
        drive(1, 1, 0, 1, 0, 0, 8'h00); tick();
        drive(1, 1, 0, 0, 0, 1, 8'h1A); tick();
        chk("R3 write after save", q_out, 8'h1A);
        drive(1, 1, 0, 0, 1, 0, 8'h00); tick();
        chk("R7 level capture restored", q_out, 8'h17);

        // R9 sleep cycle with R10 save while off
        drive(1, 1, 0, 0, 0, 1, 8'h9E); tick();
        drive(1, 1, 0, 1, 0, 0, 8'h00); tick();
        drive(1, 1, 1, 0, 0, 0, 8'h00); tick();
        drive(0, 1, 1, 0, 0, 1, 8'h44); tick();
        chk("R6 clamp while off", q_out, CLMP);
        drive(0, 1, 0, 0, 0, 1, 8'h44); #1;
        chk("R5 corrupt while off", q_out, CORR);
        drive(0, 1, 1, 1, 0, 0, 8'h00); tick();
        drive(1, 0, 1, 1, 0, 0, 8'h00); tick();
        drive(1, 1, 1, 0, 0, 0, 8'h00); tick();
        drive(1, 1, 1, 0, 1, 0, 8'h00); tick();
        drive(1, 1, 0, 0, 0, 0, 8'h00); #1;
        chk("R9 R10 restored after sleep", q_out, 8'h0E);

        // R11 collision
        drive(1, 1, 0, 0, 0, 1, 8'h2B); tick();
        drive(1, 1, 0, 1, 1, 0, 8'h00); tick();
        chk("R11 save wins data", q_out, 8'h2B);
        chk("R11 err raised", {7'd0, seq_err}, 8'h01);
        drive(1, 1, 0, 0, 0, 0, 8'h00); tick();
        chk("R11 err one cycle", {7'd0, seq_err}, 8'h00);

        // R12 restore beats write; R8 high nibble kept
        drive(1, 1, 0, 0, 0, 1, 8'h20); tick();
        drive(1, 1, 0, 0, 1, 1, 8'hFF); tick();
        chk("R12 R8 restore beats write", q_out, 8'h2B);

        // random phase against the model
        for (int k = 0; k < 600; k++) begin
            drive(($urandom % 24) != 0, ($urandom % 12) != 0, ($urandom % 4) == 0,
                  ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 2) == 1,
                  8'($urandom));
            tick();
            chk("R3/R5/R8 random output", q_out, exp_q());
            chk("R11 random err", {7'd0, seq_err}, {7'd0, m_err});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule